// File: doc/BRIEF.md
# Transmit Retry and Collision Controller

This block sequences the transmission attempts of one outgoing frame on a shared, half-duplex medium. A frame request starts the first attempt. Each attempt ends either cleanly or with a collision. After a collision the block waits in a backoff state and then retries. It gives up with a one-cycle retry-error pulse once the attempt budget is spent. A clean attempt produces a one-cycle success pulse instead.

While a frame is in flight the block tells the transmit FIFO whether the frame head has to be kept for a retransmission. It also decides, once per frame, whether a frame check sequence goes on the end of the frame. Two test and tuning knobs shape the behaviour. The first is a single-attempt mode, which shrinks the budget to one attempt and releases the FIFO hold. The second is a self-test mode that turns every attempt into a collision, but only while internal loopback is selected.

The backoff delay is not generated inside the block. It is supplied as a count on an input port and becomes a plain wait of that many cycles plus one. Configuration inputs are captured when a frame starts and stay in force until that frame ends.

Top module: `txr_retry_ctrl`

## Requirements
- R1: After reset the block is idle, with `tx_active`, `fifo_hold`, `tx_ok` and `tx_retry_err` all low. `frame_start` seen in idle makes `tx_active` high and `attempt_num` equal to 1 on the next cycle.
- R2: With `cfg_no_retry` low, each collision is followed by a retry, for up to MAX_ATTEMPTS attempts (16 by default). A collision on attempt MAX_ATTEMPTS pulses `tx_retry_err`, and `attempt_num` then reads MAX_ATTEMPTS.
- R3: An attempt that ends with `att_done` high and `att_coll` low, and with no forced collision in effect, pulses `tx_ok`. `attempt_num` then reads the number of attempts made.
- R4: With `cfg_no_retry` high at frame start, exactly one attempt is made. A collision on that attempt pulses `tx_retry_err` while `attempt_num` reads 1.
- R5: `fifo_hold` is high during the frame when `cfg_no_retry` was low at frame start, and low throughout the frame when it was high. It is low in the cycle of a `tx_ok` or `tx_retry_err` pulse.
- R6: When `cfg_force_coll` and `cfg_int_loop` are both high at frame start, every attempt counts as a collision, even when it ends with `att_done`. The frame then ends in a retry error.
- R7: When `cfg_force_coll` is high but `cfg_int_loop` is low, forcing has no effect: an attempt ending with `att_done` gives `tx_ok` on attempt 1.
- R8: After a collision that is not the last allowed, `tx_active` stays low for exactly N+1 cycles before the next attempt, where N is `bkoff_cnt` in the cycle the collision is reported.
- R9: At frame start `append_fcs` is set to 1 when `cfg_no_fcs` is 0, or when both `desc_add_fcs` and `desc_eop` are 1. Otherwise it is set to 0. The value holds for the whole frame.
- R10: `tx_ok` and `tx_retry_err` are never high together. Each lasts one cycle, after which the block is idle with `tx_active` low.
- R11: When `att_done` and `att_coll` are both high in the same cycle, the attempt counts as a collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Request to send a frame, taken only in idle |
| cfg_no_retry | input | 1 | Single-attempt mode, no FIFO hold |
| cfg_force_coll | input | 1 | Force a collision on every attempt |
| cfg_int_loop | input | 1 | Internal loopback selected |
| cfg_no_fcs | input | 1 | Suppress the frame check sequence |
| desc_add_fcs | input | 1 | Descriptor requests a frame check sequence |
| desc_eop | input | 1 | Descriptor marks end of packet |
| att_done | input | 1 | Current attempt ended |
| att_coll | input | 1 | Current attempt saw a collision |
| bkoff_cnt | input | BKOFF_W | Backoff wait length in cycles, minus one |
| tx_active | output | 1 | An attempt is in progress |
| fifo_hold | output | 1 | FIFO must keep the frame head |
| tx_ok | output | 1 | One-cycle success pulse |
| tx_retry_err | output | 1 | One-cycle retry-error pulse |
| attempt_num | output | ATT_W | Current attempt number |
| append_fcs | output | 1 | Append a frame check sequence to this frame |

## Verification
The bench keeps MAX_ATTEMPTS at its default of 16 and narrows BKOFF_W to 4. With these values the full ladder of sixteen attempts, including the last-attempt boundary (fifteen collisions then success, and sixteen collisions then failure), fits in a few hundred cycles. Backoff lengths of 0 to 3 exercise the N+1 wait, including the shortest, zero-length case. Single-attempt and forced-collision modes are combined with each other and with loopback off, so that the budget of one and the loopback gating are both reached.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_XMIT     = 3'd1,
    ST_BACKOFF  = 3'd2,
    ST_DONE_OK  = 3'd3,
    ST_DONE_ERR = 3'd4
  } txr_state_e;
endpackage

// File: rtl/txr_attempt_ctr.sv
module txr_attempt_ctr #(
  parameter int ATT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_one,
  input  logic             inc,
  output logic [ATT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (clr_one) cnt <= ATT_W'(1);
    else if (inc)     cnt <= cnt + ATT_W'(1);
  end
endmodule

// File: rtl/txr_bkoff_timer.sv
module txr_bkoff_timer #(
  parameter int BKOFF_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [BKOFF_W-1:0] load_val,
  output logic               expired
);
  logic [BKOFF_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (load)          remain <= load_val;
    else if (remain != '0)  remain <= remain - BKOFF_W'(1);
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/txr_fcs_sel.sv
module txr_fcs_sel (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  input  logic no_fcs,
  input  logic add_fcs,
  input  logic eop,
  output logic append
);
  always_ff @(posedge clk) begin
    if (rst)          append <= 1'b0;
    else if (capture) append <= (!no_fcs) || (add_fcs && eop);
  end
endmodule

// File: rtl/txr_retry_ctrl.sv
module txr_retry_ctrl
  import txr_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 16,
  parameter int BKOFF_W      = 10,
  parameter int ATT_W        = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic               cfg_no_retry,
  input  logic               cfg_force_coll,
  input  logic               cfg_int_loop,
  input  logic               cfg_no_fcs,
  input  logic               desc_add_fcs,
  input  logic               desc_eop,
  input  logic               att_done,
  input  logic               att_coll,
  input  logic [BKOFF_W-1:0] bkoff_cnt,
  output logic               tx_active,
  output logic               fifo_hold,
  output logic               tx_ok,
  output logic               tx_retry_err,
  output logic [ATT_W-1:0]   attempt_num,
  output logic               append_fcs
);
  localparam logic [ATT_W-1:0] FULL_BUDGET = ATT_W'(MAX_ATTEMPTS);
  localparam logic [ATT_W-1:0] ONE_BUDGET  = ATT_W'(1);

  txr_state_e state;
  logic nr_lat, frc_lat;
  logic start_go, att_end, collided, budget_out, tmr_load, tmr_expired, cnt_inc;
  logic [ATT_W-1:0] budget;

  assign start_go   = (state == ST_IDLE) && frame_start;
  assign att_end    = att_done || att_coll;
  assign collided   = att_coll || frc_lat;
  assign budget     = nr_lat ? ONE_BUDGET : FULL_BUDGET;
  assign budget_out = (attempt_num >= budget);
  assign tmr_load   = (state == ST_XMIT) && att_end && collided && !budget_out;
  assign cnt_inc    = (state == ST_BACKOFF) && tmr_expired;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      fifo_hold <= 1'b0;
      nr_lat    <= 1'b0;
      frc_lat   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (frame_start) begin
            state     <= ST_XMIT;
            nr_lat    <= cfg_no_retry;
            frc_lat   <= cfg_force_coll && cfg_int_loop;
            fifo_hold <= !cfg_no_retry;
          end
        end
        ST_XMIT: begin
          if (att_end) begin
            if (collided) begin
              if (budget_out) begin
                state     <= ST_DONE_ERR;
                fifo_hold <= 1'b0;
              end else begin
                state <= ST_BACKOFF;
              end
            end else begin
              state     <= ST_DONE_OK;
              fifo_hold <= 1'b0;
            end
          end
        end
        ST_BACKOFF: begin
          if (tmr_expired) state <= ST_XMIT;
        end
        ST_DONE_OK:  state <= ST_IDLE;
        ST_DONE_ERR: state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  assign tx_active    = (state == ST_XMIT);
  assign tx_ok        = (state == ST_DONE_OK);
  assign tx_retry_err = (state == ST_DONE_ERR);

  txr_attempt_ctr #(.ATT_W(ATT_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .clr_one (start_go),
    .inc     (cnt_inc),
    .cnt     (attempt_num)
  );

  txr_bkoff_timer #(.BKOFF_W(BKOFF_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (bkoff_cnt),
    .expired  (tmr_expired)
  );

  txr_fcs_sel u_fcs (
    .clk     (clk),
    .rst     (rst),
    .capture (start_go),
    .no_fcs  (cfg_no_fcs),
    .add_fcs (desc_add_fcs),
    .eop     (desc_eop),
    .append  (append_fcs)
  );
endmodule

// File: rtl/txr_retry_chk.sv
module txr_retry_chk #(
  parameter int MAX_ATTEMPTS = 16,
  parameter int ATT_W        = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_active,
  input logic             fifo_hold,
  input logic             tx_ok,
  input logic             tx_retry_err,
  input logic [ATT_W-1:0] attempt_num,
  input logic             nr_lat
);
  a_r10_ok_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_ok |=> !tx_ok && !tx_active);
  a_r10_err_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_retry_err |=> !tx_retry_err && !tx_active);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(tx_ok && tx_retry_err));
  a_r5_hold_drop: assert property (@(posedge clk) disable iff (rst)
    (tx_ok || tx_retry_err) |-> !fifo_hold);
  a_r5_no_hold_single: assert property (@(posedge clk) disable iff (rst)
    (tx_active && nr_lat) |-> !fifo_hold);
  a_r4_single_budget: assert property (@(posedge clk) disable iff (rst)
    (tx_active && nr_lat) |-> (attempt_num == ATT_W'(1)));
  a_r2_budget_bound: assert property (@(posedge clk) disable iff (rst)
    attempt_num <= ATT_W'(MAX_ATTEMPTS));
endmodule

bind txr_retry_ctrl txr_retry_chk #(
  .MAX_ATTEMPTS (MAX_ATTEMPTS),
  .ATT_W        (ATT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tx_active    (tx_active),
  .fifo_hold    (fifo_hold),
  .tx_ok        (tx_ok),
  .tx_retry_err (tx_retry_err),
  .attempt_num  (attempt_num),
  .nr_lat       (nr_lat)
);

// File: tb/txr_retry_ctrl_tb.sv
module txr_retry_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXA  = 16;
  localparam int BKW   = 4;
  localparam int ATTW  = $clog2(MAXA + 1);

  typedef struct packed {
    logic       nr;
    logic       frc;
    logic       lp;
    logic       nfcs;
    logic       addf;
    logic       eop;
    logic       both;
    logic [4:0] ncoll;
    logic [3:0] bk;
    logic       exp_ok;
    logic [4:0] exp_att;
    logic       exp_fcs;
    logic       exp_hold;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0, 4'd2,1'b1,5'd1, 1'b1,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,5'd3, 4'd0,1'b1,5'd4, 1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,5'd15,4'd1,1'b1,5'd16,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,5'd16,4'd3,1'b0,5'd16,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0, 4'd1,1'b1,5'd1, 1'b1,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd1, 4'd1,1'b0,5'd1, 1'b1,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,5'd0, 4'd0,1'b0,5'd16,1'b1,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0, 4'd2,1'b1,5'd1, 1'b1,1'b1},
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,5'd0, 4'd0,1'b0,5'd1, 1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,5'd2, 4'd1,1'b1,5'd3, 1'b1,1'b1}
  };

  logic clk = 1'b0;
  logic rst;
  logic frame_start, cfg_no_retry, cfg_force_coll, cfg_int_loop, cfg_no_fcs;
  logic desc_add_fcs, desc_eop, att_done, att_coll;
  logic [BKW-1:0] bkoff_cnt;
  logic tx_active, fifo_hold, tx_ok, tx_retry_err, append_fcs;
  logic [ATTW-1:0] attempt_num;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txr_retry_ctrl #(.MAX_ATTEMPTS(MAXA), .BKOFF_W(BKW)) u_dut (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .cfg_no_retry(cfg_no_retry), .cfg_force_coll(cfg_force_coll),
    .cfg_int_loop(cfg_int_loop), .cfg_no_fcs(cfg_no_fcs),
    .desc_add_fcs(desc_add_fcs), .desc_eop(desc_eop),
    .att_done(att_done), .att_coll(att_coll), .bkoff_cnt(bkoff_cnt),
    .tx_active(tx_active), .fifo_hold(fifo_hold), .tx_ok(tx_ok),
    .tx_retry_err(tx_retry_err), .attempt_num(attempt_num),
    .append_fcs(append_fcs)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    int left;
    bit fin;
    int gap;
    int guard;
    left = int'(v.ncoll);
    fin  = 1'b0;
    @(negedge clk);
    cfg_no_retry = v.nr; cfg_force_coll = v.frc; cfg_int_loop = v.lp;
    cfg_no_fcs = v.nfcs; desc_add_fcs = v.addf; desc_eop = v.eop;
    bkoff_cnt = v.bk; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk(tx_active == 1'b1, "R1 active after start", int'(tx_active), 1);
    chk(attempt_num == 1, "R1 first attempt number", int'(attempt_num), 1);
    // change config mid-frame; captured values must stay in force
    cfg_no_fcs = ~v.nfcs; cfg_no_retry = ~v.nr;
    guard = 0;
    while (!fin && guard < 40) begin
      guard++;
      chk(fifo_hold == v.exp_hold, "R5 hold during attempt", int'(fifo_hold), int'(v.exp_hold));
      chk(append_fcs == v.exp_fcs, "R9 fcs decision", int'(append_fcs), int'(v.exp_fcs));
      if (left > 0) begin
        att_coll = 1'b1; att_done = v.both; left--;
      end else begin
        att_done = 1'b1; att_coll = 1'b0;
      end
      @(negedge clk);
      att_done = 1'b0; att_coll = 1'b0;
      if (tx_ok || tx_retry_err) begin
        fin = 1'b1;
        chk(tx_ok == v.exp_ok, $sformatf("R3 R2 R4 R6 R7 R11 outcome vec%0d", idx),
            int'(tx_ok), int'(v.exp_ok));
        chk(tx_retry_err == !v.exp_ok, $sformatf("R2 R4 R6 retry err vec%0d", idx),
            int'(tx_retry_err), int'(!v.exp_ok));
        chk(attempt_num == v.exp_att, $sformatf("R2 R3 attempt count vec%0d", idx),
            int'(attempt_num), int'(v.exp_att));
        chk(fifo_hold == 1'b0, "R5 hold low at end", int'(fifo_hold), 0);
        @(negedge clk);
        chk(!tx_ok && !tx_retry_err && !tx_active, "R10 single pulse then idle",
            int'({tx_ok, tx_retry_err, tx_active}), 0);
      end else begin
        gap = 1;
        while (!tx_active && gap < 40) begin
          @(negedge clk);
          if (!tx_active) gap++;
        end
        chk(gap == int'(v.bk) + 1, $sformatf("R8 backoff length vec%0d", idx),
            gap, int'(v.bk) + 1);
      end
    end
    chk(fin, "R10 frame finished", int'(fin), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; frame_start = 1'b0; cfg_no_retry = 1'b0; cfg_force_coll = 1'b0;
    cfg_int_loop = 1'b0; cfg_no_fcs = 1'b0; desc_add_fcs = 1'b0; desc_eop = 1'b0;
    att_done = 1'b0; att_coll = 1'b0; bkoff_cnt = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_active && !fifo_hold && !tx_ok && !tx_retry_err, "R1 reset state",
        int'({tx_active, fifo_hold, tx_ok, tx_retry_err}), 0);

    for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

    // idle: attempt-end inputs without a frame must not produce pulses
    @(negedge clk);
    att_done = 1'b1; att_coll = 1'b1;
    @(negedge clk);
    att_done = 1'b0; att_coll = 1'b0;
    chk(!tx_ok && !tx_retry_err && !tx_active, "R10 idle ignores attempt inputs",
        int'({tx_ok, tx_retry_err, tx_active}), 0);

    // reset in the middle of a frame returns to idle
    @(negedge clk);
    cfg_no_retry = 1'b0; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!tx_active && !fifo_hold, "R1 reset aborts frame",
        int'({tx_active, fifo_hold}), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule